// File: doc/BRIEF.md
# ADC Start-of-Conversion Sequencer

This block is the digital controller in front of a multi-channel ADC. It holds a small set of conversion slots. Each slot is set up with the analog input to sample, the external trigger that starts it, and the length of its sample-and-hold window. A trigger marks every slot that listens to it as pending. The sequencer then serves the pending slots one at a time. For each slot it drives the input-mux select, holds the sample window, runs the conversion phase, and stores the converter's data word in that slot's result register.

A single interrupt line follows one chosen slot. It can pulse when that slot's conversion phase starts, or once its result has been stored. In single-shot mode a raised flag blocks further pulses until software clears it. In continuous mode every qualifying event pulses. Configuration is written through a simple address/data write port. The analog converter is not part of the block: its output word enters on a data input and is sampled on the last conversion cycle.

Top module: `adc_soc_seq`

## Requirements
- R1: After reset, no slot is pending, the sequencer is idle (`busy_o`=0, `sample_o`=0), `adc_ch_o`=0, every result is 0, `int_o`=0 and `int_flag_o`=0, and all configuration fields are 0.
- R2: A write to address s (s < NUM_SLOTS) loads slot s with channel = data[CH_W-1:0], trigger code = data[CH_W+TRIG_W-1:CH_W] and acquisition = the next ACQ_W bits. A write to address NUM_SLOTS loads the interrupt control: bits [SLOT_W-1:0] source slot, bit SLOT_W enable, bit SLOT_W+1 continuous, bit SLOT_W+2 late position. A write to address NUM_SLOTS+1 with data bit 0 set clears the interrupt flag. Writes take effect from the next cycle.
- R3: A served slot holds `sample_o` high for exactly acquisition+1 cycles while `adc_ch_o` shows its channel. The slot then keeps `busy_o` high for CONV_CYCLES conversion cycles. On the last of these cycles `adc_data_i` is captured, and it appears in the slot's field of `result_o` on the next cycle.
- R4: Trigger code k (1 to 2^TRIG_W-1) makes a slot pending when `trig_i[k]` is high at a clock edge. Code 0 never triggers, so `trig_i[0]` has no effect.
- R5: Among pending slots, the next one served is the first found when searching upward from the slot after the last one served, wrapping from NUM_SLOTS-1 to 0. From reset the search starts at slot 0.
- R6: A trigger for a slot that is already pending is merged: the slot is converted once. A trigger that arrives while the slot is being served queues it again.
- R7: The interrupt fires only for events of the slot named in the source field, and only while enable is 1. A source value of NUM_SLOTS or above never fires.
- R8: With late position = 1, `int_o` pulses for one cycle, together with the result update. With late position = 0, it pulses in the first conversion cycle, after the sample window closes.
- R9: Each pulse sets `int_flag_o`. In single-shot mode no pulse occurs while the flag is set. In continuous mode pulses occur regardless of the flag. The flag clears only by the clear write, and a pulse in the same cycle takes priority over the clear.
- R10: When another slot is pending at the end of a conversion, its sample window begins in the next cycle, with no idle cycle between the two slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | ADC clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | $clog2(NUM_SLOTS+2) | Register write address |
| wr_data_i | input | CH_W+TRIG_W+ACQ_W | Register write data |
| trig_i | input | 2**TRIG_W | Trigger event inputs, one cycle per event |
| adc_data_i | input | DATA_W | Converter output word |
| adc_ch_o | output | CH_W | Input-mux channel select |
| sample_o | output | 1 | Sample-and-hold window active |
| busy_o | output | 1 | A slot is being sampled or converted |
| result_o | output | NUM_SLOTS*DATA_W | Result registers, slot s at bits [s*DATA_W +: DATA_W] |
| int_o | output | 1 | Interrupt pulse |
| int_flag_o | output | 1 | Interrupt flag |

## Verification
The bench builds the block with six slots, 4-bit channels, 3-bit trigger codes, 6-bit acquisition fields, 10-bit data, and CONV_CYCLES reduced to 5. With these values a full sweep of all slots, with acquisition lengths from 0 to 6, takes well under a hundred cycles. That leaves room to exercise pointer wrap, merged triggers, code 0, both pulse positions and both flag modes in one short run. The converter word changes every cycle, so a capture one cycle early or late shows up as a wrong result value.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2
    } seq_phase_e;

endpackage

// File: rtl/adc_seq_cfg.sv
module adc_seq_cfg #(
    parameter int NUM_SLOTS = 6,
    parameter int CH_W      = 4,
    parameter int TRIG_W    = 3,
    parameter int ACQ_W     = 6,
    parameter int SLOT_W    = 3,
    parameter int ADDR_W    = 3,
    parameter int WD_W      = CH_W + TRIG_W + ACQ_W
) (
    input  logic                                 clk_i,
    input  logic                                 rst_ni,
    input  logic                                 wr_en_i,
    input  logic [ADDR_W-1:0]                    wr_addr_i,
    input  logic [WD_W-1:0]                      wr_data_i,
    output logic [NUM_SLOTS-1:0][CH_W-1:0]       slot_ch_o,
    output logic [NUM_SLOTS-1:0][TRIG_W-1:0]     slot_trg_o,
    output logic [NUM_SLOTS-1:0][ACQ_W-1:0]      slot_acq_o,
    output logic [SLOT_W-1:0]                    irq_sel_o,
    output logic                                 irq_en_o,
    output logic                                 irq_cont_o,
    output logic                                 irq_late_o,
    output logic                                 irq_clr_o
);

    typedef struct packed {
        logic [NUM_SLOTS-1:0][CH_W-1:0]   ch;
        logic [NUM_SLOTS-1:0][TRIG_W-1:0] trg;
        logic [NUM_SLOTS-1:0][ACQ_W-1:0]  acq;
        logic [SLOT_W-1:0]                sel;
        logic                             en;
        logic                             cont;
        logic                             late;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en_i) begin
            for (int s = 0; s < NUM_SLOTS; s++) begin
                if (wr_addr_i == ADDR_W'(s)) begin
                    cfg_d.ch[s]  = wr_data_i[CH_W-1:0];
                    cfg_d.trg[s] = wr_data_i[CH_W+TRIG_W-1:CH_W];
                    cfg_d.acq[s] = wr_data_i[CH_W+TRIG_W+ACQ_W-1:CH_W+TRIG_W];
                end
            end
            if (wr_addr_i == ADDR_W'(NUM_SLOTS)) begin
                cfg_d.sel  = wr_data_i[SLOT_W-1:0];
                cfg_d.en   = wr_data_i[SLOT_W];
                cfg_d.cont = wr_data_i[SLOT_W+1];
                cfg_d.late = wr_data_i[SLOT_W+2];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cfg_q <= '0;
        else         cfg_q <= cfg_d;
    end

    assign slot_ch_o  = cfg_q.ch;
    assign slot_trg_o = cfg_q.trg;
    assign slot_acq_o = cfg_q.acq;
    assign irq_sel_o  = cfg_q.sel;
    assign irq_en_o   = cfg_q.en;
    assign irq_cont_o = cfg_q.cont;
    assign irq_late_o = cfg_q.late;
    assign irq_clr_o  = wr_en_i && (wr_addr_i == ADDR_W'(NUM_SLOTS + 1)) && wr_data_i[0];

endmodule

// File: rtl/adc_seq_rr.sv
module adc_seq_rr #(
    parameter int NUM_SLOTS = 6,
    parameter int SLOT_W    = 3
) (
    input  logic [NUM_SLOTS-1:0] pend_i,
    input  logic [SLOT_W-1:0]    base_i,
    output logic                 gnt_valid_o,
    output logic [SLOT_W-1:0]    gnt_idx_o
);

    always_comb begin
        gnt_valid_o = 1'b0;
        gnt_idx_o   = '0;
        for (int k = 0; k < NUM_SLOTS; k++) begin
            int j;
            j = (int'(base_i) + k) % NUM_SLOTS;
            if (!gnt_valid_o && pend_i[j]) begin
                gnt_valid_o = 1'b1;
                gnt_idx_o   = SLOT_W'(j);
            end
        end
    end

endmodule

// File: rtl/adc_seq_irq.sv
module adc_seq_irq #(
    parameter int SLOT_W = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              soc_ev_i,
    input  logic              eoc_ev_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  logic [SLOT_W-1:0] sel_i,
    input  logic              en_i,
    input  logic              cont_i,
    input  logic              late_i,
    input  logic              clr_i,
    output logic              int_o,
    output logic              flag_o
);

    typedef struct packed {
        logic pulse;
        logic flag;
    } irq_t;

    irq_t irq_d, irq_q;
    logic ev, fire;

    always_comb begin
        ev   = late_i ? eoc_ev_i : soc_ev_i;
        fire = en_i && ev && (slot_i == sel_i) && (cont_i || !irq_q.flag);
        irq_d.pulse = fire;
        if (fire)       irq_d.flag = 1'b1;
        else if (clr_i) irq_d.flag = 1'b0;
        else            irq_d.flag = irq_q.flag;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) irq_q <= '0;
        else         irq_q <= irq_d;
    end

    assign int_o  = irq_q.pulse;
    assign flag_o = irq_q.flag;

endmodule

// File: rtl/adc_soc_seq.sv
module adc_soc_seq #(
    parameter int NUM_SLOTS   = 6,
    parameter int CH_W        = 4,
    parameter int TRIG_W      = 3,
    parameter int ACQ_W       = 6,
    parameter int DATA_W      = 12,
    parameter int CONV_CYCLES = 13
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [$clog2(NUM_SLOTS+2)-1:0] wr_addr_i,
    input  logic [CH_W+TRIG_W+ACQ_W-1:0]  wr_data_i,
    input  logic [(1<<TRIG_W)-1:0]        trig_i,
    input  logic [DATA_W-1:0]             adc_data_i,
    output logic [CH_W-1:0]               adc_ch_o,
    output logic                          sample_o,
    output logic                          busy_o,
    output logic [NUM_SLOTS*DATA_W-1:0]   result_o,
    output logic                          int_o,
    output logic                          int_flag_o
);
    import adc_seq_pkg::*;

    localparam int SLOT_W = $clog2(NUM_SLOTS);
    localparam int ADDR_W = $clog2(NUM_SLOTS + 2);
    localparam int WD_W   = CH_W + TRIG_W + ACQ_W;
    localparam int CV_W   = $clog2(CONV_CYCLES + 1);
    localparam int CNT_W  = (ACQ_W > CV_W) ? ACQ_W : CV_W;

    typedef struct packed {
        seq_phase_e                       phase;
        logic [CNT_W-1:0]                 cnt;
        logic [SLOT_W-1:0]                cur;
        logic [CH_W-1:0]                  ch;
        logic [NUM_SLOTS-1:0]             pend;
        logic [SLOT_W-1:0]                rr;
        logic [NUM_SLOTS-1:0][DATA_W-1:0] res;
    } seq_t;

    seq_t seq_d, seq_q;

    logic [NUM_SLOTS-1:0][CH_W-1:0]   slot_ch;
    logic [NUM_SLOTS-1:0][TRIG_W-1:0] slot_trg;
    logic [NUM_SLOTS-1:0][ACQ_W-1:0]  slot_acq;
    logic [SLOT_W-1:0]                irq_sel;
    logic                             irq_en, irq_cont, irq_late, irq_clr;
    logic [NUM_SLOTS-1:0]             hit;
    logic                             gnt_valid;
    logic [SLOT_W-1:0]                gnt_idx;
    logic                             take, soc_ev, eoc_ev;

    adc_seq_cfg #(
        .NUM_SLOTS(NUM_SLOTS), .CH_W(CH_W), .TRIG_W(TRIG_W), .ACQ_W(ACQ_W),
        .SLOT_W(SLOT_W), .ADDR_W(ADDR_W), .WD_W(WD_W)
    ) u_cfg (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_en_i    (wr_en_i),
        .wr_addr_i  (wr_addr_i),
        .wr_data_i  (wr_data_i),
        .slot_ch_o  (slot_ch),
        .slot_trg_o (slot_trg),
        .slot_acq_o (slot_acq),
        .irq_sel_o  (irq_sel),
        .irq_en_o   (irq_en),
        .irq_cont_o (irq_cont),
        .irq_late_o (irq_late),
        .irq_clr_o  (irq_clr)
    );

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_hit
        assign hit[s] = (slot_trg[s] != '0) && trig_i[slot_trg[s]];
    end

    adc_seq_rr #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_rr (
        .pend_i      (seq_q.pend),
        .base_i      (seq_q.rr),
        .gnt_valid_o (gnt_valid),
        .gnt_idx_o   (gnt_idx)
    );

    always_comb begin
        seq_d  = seq_q;
        take   = 1'b0;
        soc_ev = 1'b0;
        eoc_ev = 1'b0;
        seq_d.pend = seq_q.pend | hit;
        unique case (seq_q.phase)
            PH_IDLE: take = gnt_valid;
            PH_SAMPLE: begin
                if (seq_q.cnt == '0) begin
                    seq_d.phase = PH_CONV;
                    seq_d.cnt   = CNT_W'(CONV_CYCLES - 1);
                    soc_ev      = 1'b1;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            PH_CONV: begin
                if (seq_q.cnt == '0) begin
                    seq_d.res[seq_q.cur] = adc_data_i;
                    eoc_ev      = 1'b1;
                    seq_d.phase = PH_IDLE;
                    take        = gnt_valid;
                end else begin
                    seq_d.cnt = seq_q.cnt - CNT_W'(1);
                end
            end
            default: seq_d.phase = PH_IDLE;
        endcase
        if (take) begin
            seq_d.phase         = PH_SAMPLE;
            seq_d.cur           = gnt_idx;
            seq_d.ch            = slot_ch[gnt_idx];
            seq_d.cnt           = CNT_W'(slot_acq[gnt_idx]);
            seq_d.pend[gnt_idx] = 1'b0;
            seq_d.rr            = (gnt_idx == SLOT_W'(NUM_SLOTS - 1)) ? '0 : gnt_idx + SLOT_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) seq_q <= '0;
        else         seq_q <= seq_d;
    end

    adc_seq_irq #(.SLOT_W(SLOT_W)) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .soc_ev_i (soc_ev),
        .eoc_ev_i (eoc_ev),
        .slot_i   (seq_q.cur),
        .sel_i    (irq_sel),
        .en_i     (irq_en),
        .cont_i   (irq_cont),
        .late_i   (irq_late),
        .clr_i    (irq_clr),
        .int_o    (int_o),
        .flag_o   (int_flag_o)
    );

    assign adc_ch_o = seq_q.ch;
    assign sample_o = (seq_q.phase == PH_SAMPLE);
    assign busy_o   = (seq_q.phase != PH_IDLE);
    assign result_o = seq_q.res;

endmodule

// File: rtl/adc_soc_seq_chk.sv
module adc_soc_seq_chk #(
    parameter int CH_W = 4
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            sample_o,
    input logic            busy_o,
    input logic [CH_W-1:0] adc_ch_o,
    input logic            int_o,
    input logic            int_flag_o,
    input logic            irq_cont
);

    AST_CH_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sample_o && $past(sample_o)) |-> $stable(adc_ch_o)); // R3

    AST_SAMPLE_TO_CONV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sample_o) |-> busy_o); // R3

    AST_INT_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |=> !int_o); // R8

    AST_INT_SETS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        int_o |-> int_flag_o); // R9

    AST_SINGLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (int_flag_o && !irq_cont) |=> !int_o); // R9

endmodule

bind adc_soc_seq adc_soc_seq_chk #(.CH_W(CH_W)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sample_o   (sample_o),
    .busy_o     (busy_o),
    .adc_ch_o   (adc_ch_o),
    .int_o      (int_o),
    .int_flag_o (int_flag_o),
    .irq_cont   (irq_cont)
);

// File: tb/adc_soc_seq_tb.sv
module adc_soc_seq_tb;
    localparam int NS = 6, CHW = 4, TRW = 3, ACQW = 6, DW = 10, CONV = 5;
    localparam int NT = 1 << TRW;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              wr_en = 1'b0;
    logic [2:0]        wr_addr = '0;
    logic [12:0]       wr_data = '0;
    logic [NT-1:0]     trig = '0;
    logic [DW-1:0]     adc_data = '0;
    logic [CHW-1:0]    adc_ch;
    logic              sample, busy, int_p, int_flag;
    logic [NS*DW-1:0]  result;

    int vectors = 0, errors = 0, cycles = 0;
    bit done = 0;
    string req = "R1";

    always #10 clk = ~clk;

    adc_soc_seq #(.NUM_SLOTS(NS), .CH_W(CHW), .TRIG_W(TRW), .ACQ_W(ACQW),
                  .DATA_W(DW), .CONV_CYCLES(CONV)) u_dut (
        .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .trig_i(trig), .adc_data_i(adc_data),
        .adc_ch_o(adc_ch), .sample_o(sample), .busy_o(busy), .result_o(result),
        .int_o(int_p), .int_flag_o(int_flag));

    // behavioural reference model
    int m_phase = 0, m_cnt = 0, m_cur = 0, m_ch = 0, m_rr = 0;
    int m_int = 0, m_flag = 0;
    int m_pend[NS], m_res[NS], c_ch[NS], c_tr[NS], c_acq[NS];
    int c_sel = 0, c_en = 0, c_cont = 0, c_late = 0;

    initial for (int s = 0; s < NS; s++) begin
        m_pend[s] = 0; m_res[s] = 0; c_ch[s] = 0; c_tr[s] = 0; c_acq[s] = 0;
    end

    always @(negedge clk) adc_data <= adc_data + 10'd37;

    always @(posedge clk) begin
        if (rst_n) begin
            int g, socv, eocv, fire, clr;
            g = -1;
            if (m_phase == 0 || (m_phase == 2 && m_cnt == 0))
                for (int k = 0; k < NS; k++)
                    if (g < 0 && m_pend[(m_rr + k) % NS] != 0) g = (m_rr + k) % NS;
            socv = (m_phase == 1 && m_cnt == 0) ? 1 : 0;
            eocv = (m_phase == 2 && m_cnt == 0) ? 1 : 0;
            fire = (c_en != 0 && c_sel == m_cur && ((c_late != 0) ? eocv : socv) != 0
                    && (c_cont != 0 || m_flag == 0)) ? 1 : 0;
            clr  = (wr_en && wr_addr == 3'd7 && wr_data[0]) ? 1 : 0;
            m_int = fire;
            if (fire != 0) m_flag = 1; else if (clr != 0) m_flag = 0;
            if (eocv != 0) m_res[m_cur] = int'(adc_data);
            if (m_phase == 1) begin
                if (m_cnt == 0) begin m_phase = 2; m_cnt = CONV - 1; end else m_cnt--;
            end else if (m_phase == 2) begin
                if (m_cnt == 0) m_phase = 0; else m_cnt--;
            end
            if (g >= 0) begin
                m_phase = 1; m_cur = g; m_ch = c_ch[g]; m_cnt = c_acq[g]; m_rr = (g + 1) % NS;
            end
            for (int s = 0; s < NS; s++)
                if (c_tr[s] != 0 && trig[c_tr[s]]) m_pend[s] = 1;
            if (g >= 0) m_pend[g] = 0;
            if (wr_en) begin
                if (wr_addr < 3'd6) begin
                    c_ch[wr_addr]  = int'(wr_data[3:0]);
                    c_tr[wr_addr]  = int'(wr_data[6:4]);
                    c_acq[wr_addr] = int'(wr_data[12:7]);
                end else if (wr_addr == 3'd6) begin
                    c_sel = int'(wr_data[2:0]); c_en = int'(wr_data[3]);
                    c_cont = int'(wr_data[4]); c_late = int'(wr_data[5]);
                end
            end
        end
    end

    task automatic cmp(string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s act=%0d exp=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // every cycle compare: R3 timing/results, R8/R9 interrupt, tagged by scenario
    always @(negedge clk) begin
        if (rst_n && !done) begin
            cmp("busy_o", int'(busy), (m_phase != 0) ? 1 : 0);
            cmp("sample_o", int'(sample), (m_phase == 1) ? 1 : 0);
            cmp("adc_ch_o", int'(adc_ch), m_ch);
            cmp("int_o", int'(int_p), m_int);
            cmp("int_flag_o", int'(int_flag), m_flag);
            for (int s = 0; s < NS; s++)
                cmp($sformatf("result[%0d]", s), int'(result[s*DW +: DW]), m_res[s]);
        end
    end

    task automatic wr(input logic [2:0] a, input logic [12:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    function automatic logic [12:0] slot_word(int ch, int tr, int acq);
        return {6'(acq), 3'(tr), 4'(ch)};
    endfunction

    function automatic logic [12:0] irq_word(int sel, int en, int cont, int late);
        return 13'({1'(late), 1'(cont), 1'(en), 3'(sel)});
    endfunction

    task automatic pulse(input logic [NT-1:0] t);
        @(negedge clk); trig = t;
        @(negedge clk); trig = '0;
    endtask

    task automatic run(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        // R1: reset state
        run(3);
        rst_n = 1'b1;
        run(2);
        req = "R1";
        cmp("reset busy", int'(busy), 0);
        cmp("reset flag", int'(int_flag), 0);

        // R2 R3 R10: configure all slots on trigger code 5, sweep
        req = "R2/R3/R10";
        wr(0, slot_word(4, 5, 6)); wr(1, slot_word(2, 5, 0));
        wr(2, slot_word(3, 5, 3)); wr(3, slot_word(5, 5, 2));
        wr(4, slot_word(7, 5, 1)); wr(5, slot_word(9, 5, 2));
        wr(6, irq_word(5, 1, 0, 1));
        pulse(8'h20);
        run(90);

        // R9: flag held, no second pulse until cleared
        req = "R9-single";
        pulse(8'h20); run(90);
        wr(7, 13'd1);
        pulse(8'h20); run(90);

        // R8: early pulse position, slot 0
        req = "R8";
        wr(6, irq_word(0, 1, 0, 0)); wr(7, 13'd1);
        pulse(8'h20); run(90);

        // R5: round-robin with wrap
        req = "R5";
        wr(0, slot_word(1, 1, 1)); wr(1, slot_word(2, 2, 0));
        wr(2, slot_word(3, 1, 2)); wr(3, slot_word(4, 3, 1));
        wr(4, slot_word(5, 2, 0)); wr(5, slot_word(6, 3, 3));
        pulse(8'h08); run(3); pulse(8'h02); run(60);
        pulse(8'h0E); run(70);

        // R6: repeated triggers while pending / in service
        req = "R6";
        @(negedge clk); trig = 8'h04; run(12); trig = '0;
        run(60);

        // R4: code 0 never triggers; trig[0] ignored
        req = "R4";
        wr(2, slot_word(8, 0, 1));
        pulse(8'h01); run(10);
        pulse(8'hFF); run(80);

        // R9: continuous mode keeps pulsing with flag set
        req = "R9-cont";
        wr(6, irq_word(1, 1, 1, 1));
        pulse(8'h04); run(30); pulse(8'h04); run(30);

        // R7: disabled, then out-of-range source
        req = "R7";
        wr(6, irq_word(1, 0, 1, 1)); wr(7, 13'd1);
        pulse(8'h04); run(30);
        wr(6, irq_word(6, 1, 1, 1));
        pulse(8'h0E); run(60);
        req = "R7";
        cmp("int_flag after R7", int'(int_flag), 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1;
            errors++;
            $display("FAIL watchdog act=%0d exp=<20000", cycles);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule